// File: doc/BRIEF.md
# Endian-Aware Load/Store Byte Aligner

This block sits between a core's register file and a 32-bit data memory port. For loads it issues a word read, picks the addressed bytes out of the returned word, and either sign-extends or zero-extends them. For the left and right halves of an unaligned word it merges them into the old register value. For stores it places the register bytes on the right memory lanes and produces a lane-enable mask. Every store narrower than a full word is carried out as a read of the whole word, a merge of the new bytes, and a write of the whole word.

Byte order is chosen at run time by a mode input. The mode is captured with each request, so a change of mode while an access is in flight does not affect that access. The memory is assumed to return read data in the cycle after the read strobe.

A load result is presented for one cycle, one cycle after the request is accepted. This is the one-cycle load delay. A full aligned word store is written in the cycle it is accepted. A partial store keeps `busy` high for two cycles: one read cycle, then one merge-and-write cycle.

Top module: `mem_lane_aligner`

## Requirements
- R1: While reset is asserted and right after it is released, `busy`, `ld_valid`, `mem_rd` and `mem_wr` are all 0.
- R2: Byte offset k within a word (k = addr[1:0]) maps to lane 3-k (bits 31-8k down to 24-8k) when `big_endian`=1, and to lane k (bits 8k+7 down to 8k) when `big_endian`=0. The op codes are: `req_op` 0 = byte, 1 = halfword, 2 = word, 3 = left, 4 = right.
- R3: A byte or halfword load sign-extends when `req_signed`=1 and zero-extends when it is 0. A halfword at even offset k is the bytes at offsets k and k+1. The byte at offset k is the most significant byte in big-endian mode and the least significant byte in little-endian mode.
- R4: An aligned word load returns the memory word unchanged in either mode.
- R5: A left load or a right load at offset k replaces only some register bytes and keeps the others from `req_old`.
  - Big-endian, left load: register byte 3-j takes offset k+j, for j = 0 to 3-k.
  - Big-endian, right load: register byte j takes offset k-j, for j = 0 to k.
  - Little-endian, left load: register byte 3-j takes offset k-j, for j = 0 to k.
  - Little-endian, right load: register byte j takes offset k+j, for j = 0 to 3-k.
  - Stores of the same kind write the same byte pairings in the other direction.
- R6: An accepted load asserts `mem_rd` in its accept cycle. `ld_valid` is high with the result in the next cycle only.
- R7: A partial store (byte, halfword, left or right) runs idle, then read, then merge/write. `busy` is high for exactly the read cycle and the write cycle, `mem_wr` is high for one cycle, and `mem_rd` and `mem_wr` are never high together.
- R8: During the write cycle of a partial store, the lanes outside `mem_be` carry the word that was read, and the lanes inside `mem_be` carry the new bytes placed as in R2, R3 and R5. The whole-word value is therefore correct whether or not the memory honours `mem_be`.
- R9: An aligned word store is written in its accept cycle with `mem_be`=4'hF. It does not read memory and does not raise `busy`.
- R10: The byte order, the op and the operands are captured at accept. Changing `big_endian` while an access is in flight does not change its result.
- R11: Requests presented while `busy` is high are ignored.
- R12: A big-endian left load at A followed by a right load at A+3 assembles the unaligned word with byte A most significant. A little-endian right load at A followed by a left load at A+3 assembles it with byte A least significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | Byte-order mode: 1 = big-endian, 0 = little-endian |
| req_valid | input | 1 | Request present (taken only when idle) |
| req_store | input | 1 | 1 = store, 0 = load |
| req_op | input | 3 | Access kind, coded as in R2 |
| req_signed | input | 1 | Sign-extend byte and halfword loads |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Register value to store |
| req_old | input | 32 | Old destination register value, used by left and right loads |
| busy | output | 1 | Access in flight; requests are ignored |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Load result |
| mem_rd | output | 1 | Memory word read strobe |
| mem_wr | output | 1 | Memory word write strobe |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Lanes holding new store bytes |
| mem_wdata | output | 32 | Whole word to write |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |

## Verification
The assertions watch the timing on every cycle:
- the one-cycle load result pulse;
- the read-then-write order of a partial store, and that `busy` drops after the write;
- that the read and write strobes never overlap;
- that the lanes a partial store leaves alone carry the read word back unchanged;
- the single-cycle full-enable word store.

Only the bench scenarios can show that the right bytes land in the right lanes, with the right extension or merge, for every size, offset and mode. They are compared against a byte-array model. The same holds for capturing the mode at accept, for ignoring requests while busy, and for assembling an unaligned word from a left and right pair.

// File: rtl/mem_lane_aligner.sv
module mem_lane_aligner (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        big_endian,
  input  logic        req_valid,
  input  logic        req_store,
  input  logic [2:0]  req_op,
  input  logic        req_signed,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [31:0] req_old,
  output logic        busy,
  output logic        ld_valid,
  output logic [31:0] ld_data,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  localparam logic [2:0] OP_BYTE  = 3'd0;
  localparam logic [2:0] OP_HALF  = 3'd1;
  localparam logic [2:0] OP_WORD  = 3'd2;
  localparam logic [2:0] OP_LEFT  = 3'd3;
  localparam logic [2:0] OP_RIGHT = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SREAD, S_SWRITE} state_t;

  state_t      state;
  logic [2:0]  op_q;
  logic        sgn_q, bo_q;
  logic [31:0] addr_q, wdata_q, old_q;

  wire accept     = rst_n && req_valid && (state == S_IDLE);
  wire word_store = req_store && (req_op == OP_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= OP_WORD;
      sgn_q   <= 1'b0;
      bo_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      old_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          op_q    <= req_op;
          sgn_q   <= req_signed;
          bo_q    <= big_endian;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          old_q   <= req_old;
          if (!req_store)      state <= S_LOAD;
          else if (!word_store) state <= S_SREAD;
        end
        S_LOAD:   state <= S_IDLE;
        S_SREAD:  state <= S_SWRITE;
        S_SWRITE: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  wire [1:0] k      = addr_q[1:0];
  wire [1:0] b_lane = bo_q ? ~k : k;
  wire [1:0] h_lane = {addr_q[1] ^ bo_q, 1'b0};
  wire [1:0] l_sh   = bo_q ? k : ~k;
  wire [1:0] r_sh   = bo_q ? ~k : k;

  wire [31:0] byte_sh = mem_rdata >> {b_lane, 3'b000};
  wire [31:0] half_sh = mem_rdata >> {h_lane, 3'b000};
  wire [31:0] l_val   = mem_rdata << {l_sh, 3'b000};
  wire [31:0] l_msk   = 32'hFFFF_FFFF << {l_sh, 3'b000};
  wire [31:0] r_val   = mem_rdata >> {r_sh, 3'b000};
  wire [31:0] r_msk   = 32'hFFFF_FFFF >> {r_sh, 3'b000};

  always_comb begin
    case (op_q)
      OP_BYTE:  ld_data = {{24{sgn_q & byte_sh[7]}}, byte_sh[7:0]};
      OP_HALF:  ld_data = {{16{sgn_q & half_sh[15]}}, half_sh[15:0]};
      OP_LEFT:  ld_data = (l_val & l_msk) | (old_q & ~l_msk);
      OP_RIGHT: ld_data = (r_val & r_msk) | (old_q & ~r_msk);
      default:  ld_data = mem_rdata;
    endcase
  end

  logic [31:0] st_val;
  logic [3:0]  st_be;
  always_comb begin
    case (op_q)
      OP_BYTE: begin
        st_val = {4{wdata_q[7:0]}};
        st_be  = 4'b0001 << b_lane;
      end
      OP_HALF: begin
        st_val = {2{wdata_q[15:0]}};
        st_be  = 4'b0011 << h_lane;
      end
      OP_LEFT: begin
        st_val = wdata_q >> {l_sh, 3'b000};
        st_be  = 4'b1111 >> l_sh;
      end
      OP_RIGHT: begin
        st_val = wdata_q << {r_sh, 3'b000};
        st_be  = 4'b1111 << r_sh;
      end
      default: begin
        st_val = wdata_q;
        st_be  = 4'b1111;
      end
    endcase
  end

  wire [31:0] st_msk = {{8{st_be[3]}}, {8{st_be[2]}}, {8{st_be[1]}}, {8{st_be[0]}}};
  wire [31:0] merged = (st_val & st_msk) | (mem_rdata & ~st_msk);

  assign busy      = (state != S_IDLE);
  assign ld_valid  = (state == S_LOAD);
  assign mem_rd    = (accept && !req_store) || (state == S_SREAD);
  assign mem_wr    = (accept && word_store) || (state == S_SWRITE);
  assign mem_addr  = (state == S_IDLE) ? {req_addr[31:2], 2'b00} : {addr_q[31:2], 2'b00};
  assign mem_be    = (state == S_SWRITE) ? st_be : 4'b1111;
  assign mem_wdata = (state == S_SWRITE) ? merged : req_wdata;
endmodule

// File: rtl/mem_lane_aligner_chk.sv
module mem_lane_aligner_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_store,
  input logic        busy,
  input logic        ld_valid,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic [31:0] mem_rdata
);
  wire [31:0] keep = ~{{8{mem_be[3]}}, {8{mem_be[2]}}, {8{mem_be[1]}}, {8{mem_be[0]}}};

  AST_RESET_EXIT: assert property (@(posedge clk) $rose(rst_n) |-> (!busy && !ld_valid)); // R1
  AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && !busy) |=> ld_valid); // R6
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> !ld_valid); // R6
  AST_RMW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && busy) |=> (mem_wr && busy)); // R7
  AST_RMW_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && busy) |=> !busy); // R7
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R7
  AST_KEEP_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && busy) |-> (((mem_wdata ^ mem_rdata) & keep) == 32'd0)); // R8
  AST_WORD_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && !busy && mem_wr) |-> (mem_be == 4'hF && !mem_rd)); // R9
  AST_WORD_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && !busy && mem_wr) |=> !busy); // R9
endmodule

bind mem_lane_aligner mem_lane_aligner_chk chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
  .busy(busy), .ld_valid(ld_valid), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
);

// File: tb/mem_lane_aligner_test.sv
module mem_lane_aligner_test;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 16;
  localparam logic [2:0] OP_BYTE = 3'd0, OP_HALF = 3'd1, OP_WORD = 3'd2,
                         OP_LEFT = 3'd3, OP_RIGHT = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0, big_endian = 1'b1;
  logic req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0;
  logic [2:0]  req_op = OP_WORD;
  logic [31:0] req_addr = '0, req_wdata = '0, req_old = '0;
  logic busy, ld_valid, mem_rd, mem_wr;
  logic [31:0] ld_data, mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  logic [31:0] mem [WORDS];
  logic [31:0] ref_mem [WORDS];
  logic [31:0] last_wdata;
  int n_checks = 0, n_fail = 0, n_rd = 0, n_wr = 0;
  bit mem_init = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_lane_aligner uut (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .req_valid(req_valid),
    .req_store(req_store), .req_op(req_op), .req_signed(req_signed),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_old(req_old),
    .busy(busy), .ld_valid(ld_valid), .ld_data(ld_data), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (!mem_init) begin
      for (int i = 0; i < WORDS; i++) mem[i] = 32'h9E37_79B9 * (i + 1);
      mem_init = 1'b1;
    end
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr[5:2]];
      n_rd++;
    end
    if (mem_wr) begin
      for (int l = 0; l < 4; l++)
        if (mem_be[l]) mem[mem_addr[5:2]][8*l +: 8] = mem_wdata[8*l +: 8];
      last_wdata = mem_wdata;
      n_wr++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int lane(input bit be, input int k);
    return be ? 3 - k : k;
  endfunction

  function automatic logic [7:0] mb(input logic [31:0] w, input bit be, input int k);
    return w[8*lane(be, k) +: 8];
  endfunction

  function automatic logic [31:0] ref_load(input logic [2:0] op, input bit sgn, input bit be,
                                           input int k, input logic [31:0] w, input logic [31:0] old);
    logic [31:0] r;
    logic [7:0]  b;
    logic [15:0] h;
    r = old;
    case (op)
      OP_BYTE: begin
        b = mb(w, be, k);
        r = sgn ? {{24{b[7]}}, b} : {24'd0, b};
      end
      OP_HALF: begin
        h = be ? {mb(w, be, k), mb(w, be, k + 1)} : {mb(w, be, k + 1), mb(w, be, k)};
        r = sgn ? {{16{h[15]}}, h} : {16'd0, h};
      end
      OP_WORD: for (int j = 0; j < 4; j++) r[8*(3-j) +: 8] = be ? mb(w, be, j) : mb(w, be, 3 - j);
      OP_LEFT:
        if (be) for (int j = 0; j <= 3 - k; j++) r[8*(3-j) +: 8] = mb(w, be, k + j);
        else    for (int j = 0; j <= k; j++)     r[8*(3-j) +: 8] = mb(w, be, k - j);
      default:
        if (be) for (int j = 0; j <= k; j++)     r[8*j +: 8] = mb(w, be, k - j);
        else    for (int j = 0; j <= 3 - k; j++) r[8*j +: 8] = mb(w, be, k + j);
    endcase
    return r;
  endfunction

  function automatic logic [31:0] ref_store(input logic [2:0] op, input bit be, input int k,
                                            input logic [31:0] w, input logic [31:0] d);
    logic [31:0] r;
    r = w;
    case (op)
      OP_BYTE: r[8*lane(be, k) +: 8] = d[7:0];
      OP_HALF: begin
        r[8*lane(be, k) +: 8]     = be ? d[15:8] : d[7:0];
        r[8*lane(be, k + 1) +: 8] = be ? d[7:0] : d[15:8];
      end
      OP_WORD: for (int j = 0; j < 4; j++) r[8*lane(be, j) +: 8] = be ? d[8*(3-j) +: 8] : d[8*j +: 8];
      OP_LEFT:
        if (be) for (int j = 0; j <= 3 - k; j++) r[8*lane(be, k + j) +: 8] = d[8*(3-j) +: 8];
        else    for (int j = 0; j <= k; j++)     r[8*lane(be, k - j) +: 8] = d[8*(3-j) +: 8];
      default:
        if (be) for (int j = 0; j <= k; j++)     r[8*lane(be, k - j) +: 8] = d[8*j +: 8];
        else    for (int j = 0; j <= 3 - k; j++) r[8*lane(be, k + j) +: 8] = d[8*j +: 8];
    endcase
    return r;
  endfunction

  task automatic do_load(input logic [2:0] op, input bit sgn, input logic [31:0] addr,
                         input logic [31:0] old, input bit flip, input string tag,
                         output logic [31:0] got);
    logic [31:0] exp;
    exp = ref_load(op, sgn, big_endian, int'(addr[1:0]), ref_mem[addr[5:2]], old);
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b0; req_op = op; req_signed = sgn;
    req_addr = addr; req_old = old;
    #1;
    check(mem_rd === 1'b1, "R6 read strobe in accept cycle", {31'd0, mem_rd}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) big_endian = ~big_endian;
    check(ld_valid === 1'b1, "R6 result valid one cycle after accept", {31'd0, ld_valid}, 32'd1);
    check(ld_data === exp, tag, ld_data, exp);
    got = ld_data;
    @(negedge clk);
    check(ld_valid === 1'b0 && busy === 1'b0, "R6 result lasts one cycle", {30'd0, ld_valid, busy}, 32'd0);
    if (flip) big_endian = ~big_endian;
  endtask

  task automatic do_store(input logic [2:0] op, input logic [31:0] addr, input logic [31:0] d,
                          input bit flip, input string tag);
    logic [31:0] exp;
    int rd0, wr0, w;
    w   = int'(addr[5:2]);
    exp = ref_store(op, big_endian, int'(addr[1:0]), ref_mem[w], d);
    @(negedge clk);
    rd0 = n_rd; wr0 = n_wr;
    req_valid = 1'b1; req_store = 1'b1; req_op = op; req_addr = addr; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) big_endian = ~big_endian;
    if (op == OP_WORD) begin
      check(busy === 1'b0 && n_rd == rd0 && n_wr == wr0 + 1, "R9 word store direct, no read, no busy",
            32'(n_rd - rd0), 32'd0);
    end else begin
      check(busy === 1'b1 && n_rd == rd0 && n_wr == wr0, "R7 busy in read cycle", {31'd0, busy}, 32'd1);
      @(negedge clk);
      check(busy === 1'b1 && n_rd == rd0 + 1 && n_wr == wr0, "R7 read done before write",
            32'(n_rd - rd0), 32'd1);
      @(negedge clk);
      check(busy === 1'b0 && n_wr == wr0 + 1, "R7 single write then idle", 32'(n_wr - wr0), 32'd1);
      check(last_wdata === exp, "R8 whole merged word on write data", last_wdata, exp);
    end
    check(mem[w] === exp, tag, mem[w], exp);
    ref_mem[w] = exp;
    if (flip) big_endian = ~big_endian;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy === 1'b0 && ld_valid === 1'b0 && mem_rd === 1'b0 && mem_wr === 1'b0,
          "R1 quiet in reset", {28'd0, busy, ld_valid, mem_rd, mem_wr}, 32'd0);
    for (int i = 0; i < WORDS; i++) ref_mem[i] = 32'h9E37_79B9 * (i + 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && ld_valid === 1'b0 && mem_rd === 1'b0 && mem_wr === 1'b0,
          "R1 quiet after release", {28'd0, busy, ld_valid, mem_rd, mem_wr}, 32'd0);
  endtask

  task automatic t_load_sweep;
    logic [31:0] got, a;
    for (int m = 0; m < 2; m++) begin
      big_endian = m[0];
      for (int wi = 2; wi < 6; wi += 3)
        for (int k = 0; k < 4; k++) begin
          a = 32'(wi * 4 + k);
          do_load(OP_BYTE, 1'b1, a, 32'h0, 1'b0, "R2 R3 signed byte load", got);
          do_load(OP_BYTE, 1'b0, a, 32'h0, 1'b0, "R2 R3 unsigned byte load", got);
          if (k % 2 == 0) begin
            do_load(OP_HALF, 1'b1, a, 32'h0, 1'b0, "R3 signed half load", got);
            do_load(OP_HALF, 1'b0, a, 32'h0, 1'b0, "R3 unsigned half load", got);
          end
          if (k == 0) do_load(OP_WORD, 1'b0, a, 32'h0, 1'b0, "R4 word load", got);
          do_load(OP_LEFT,  1'b0, a, 32'hA5C3_1E7F, 1'b0, "R5 left load merge", got);
          do_load(OP_RIGHT, 1'b0, a, 32'hA5C3_1E7F, 1'b0, "R5 right load merge", got);
        end
    end
  endtask

  task automatic t_store_sweep;
    logic [31:0] a, d;
    for (int m = 0; m < 2; m++) begin
      big_endian = m[0];
      for (int k = 0; k < 4; k++) begin
        a = 32'(24 + k);
        d = 32'hC1D2_E3F4 ^ (32'h0101_0101 * k) ^ (32'h1000_0000 * m);
        do_store(OP_BYTE, a, d, 1'b0, "R2 R8 byte store");
        if (k % 2 == 0) do_store(OP_HALF, a, d, 1'b0, "R8 half store");
        do_store(OP_LEFT,  a, d ^ 32'h5A5A_5A5A, 1'b0, "R5 R8 left store");
        do_store(OP_RIGHT, a, d ^ 32'hF00F_0FF0, 1'b0, "R5 R8 right store");
        if (k == 0) do_store(OP_WORD, a, d, 1'b0, "R9 word store");
      end
    end
  endtask

  task automatic t_pairs;
    logic [31:0] a, p1, p2, exp;
    logic [7:0]  bt [4];
    for (int m = 0; m < 2; m++) begin
      big_endian = m[0];
      for (int o = 1; o < 4; o++) begin
        a = 32'(32 + o);
        for (int j = 0; j < 4; j++)
          bt[j] = mb(ref_mem[(int'(a) + j) / 4], m[0], (int'(a) + j) % 4);
        exp = m[0] ? {bt[0], bt[1], bt[2], bt[3]} : {bt[3], bt[2], bt[1], bt[0]};
        if (m[0]) begin
          do_load(OP_LEFT,  1'b0, a,         32'h0, 1'b0, "R12 BE left part", p1);
          do_load(OP_RIGHT, 1'b0, a + 32'd3, p1,    1'b0, "R12 BE right part", p2);
        end else begin
          do_load(OP_RIGHT, 1'b0, a,         32'h0, 1'b0, "R12 LE right part", p1);
          do_load(OP_LEFT,  1'b0, a + 32'd3, p1,    1'b0, "R12 LE left part", p2);
        end
        check(p2 === exp, "R12 unaligned word assembled", p2, exp);
      end
    end
  endtask

  task automatic t_mode_latch;
    logic [31:0] got;
    big_endian = 1'b1;
    do_store(OP_BYTE, 32'd41, 32'h0000_00E7, 1'b1, "R10 mode change during store ignored");
    do_store(OP_RIGHT, 32'd46, 32'h1234_5678, 1'b1, "R10 mode change during right store ignored");
    big_endian = 1'b0;
    do_load(OP_HALF, 1'b1, 32'd42, 32'h0, 1'b1, "R10 mode change during load ignored", got);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] exp;
    int wr0;
    big_endian = 1'b1;
    exp = ref_store(OP_BYTE, 1'b1, 1, ref_mem[12], 32'h0000_0033);
    @(negedge clk);
    wr0 = n_wr;
    req_valid = 1'b1; req_store = 1'b1; req_op = OP_BYTE; req_addr = 32'd49; req_wdata = 32'h33;
    @(posedge clk);
    @(negedge clk);
    req_op = OP_WORD; req_addr = 32'd52; req_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(n_wr == wr0 + 1, "R11 no extra write while busy", 32'(n_wr - wr0), 32'd1);
    check(mem[13] === ref_mem[13], "R11 word request during busy ignored", mem[13], ref_mem[13]);
    check(mem[12] === exp, "R11 in-flight store unaffected", mem[12], exp);
    ref_mem[12] = exp;
    @(negedge clk);
    check(busy === 1'b0 && ld_valid === 1'b0, "R11 idle afterwards", {30'd0, busy, ld_valid}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_load_sweep();
    t_store_sweep();
    t_pairs();
    t_mode_latch();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule